// File: doc/BRIEF.md
# Card Socket Power and Reset Sequencer

This block powers a removable-card socket up and down in hardware, so software does not have to spin in delay loops. A one-cycle enable command starts the power-up sequence. The socket supply is first forced to its off codes and left to discharge. Then the card supply is switched to its on code and given time to rise and settle. Then the card reset line is pulsed high, and a final wait runs before completion is reported. A disable command, or a card-removal event, starts the power-down sequence. It forces both supplies off and waits for them to collapse.

Every wait is a parameter in microseconds, scaled by a ticks-per-microsecond parameter. All waits share one down-counter, which is reloaded at each phase change. The two-bit supply codes are parameters. The block drives the supply-select and reset pins directly, and reports `busy` while a sequence runs and a one-cycle `done` when it ends.

Top module: `card_pwr_seq`

## Requirements
- R1: During and after reset, `vcc_sel` equals VCC_OFF_CODE, `vpp_sel` equals VPP_OFF_CODE, and `card_rst`, `busy` and `done` are low. Asserting reset in the middle of a sequence returns the outputs to this state.
- R2: An accepted enable command (`en_req` high for one clock while idle) shows on the cycle after that edge: both supplies at their off codes and `busy` high. The supplies stay off for (DRAIN_US + FALL_EN_US) × TICKS_PER_US cycles.
- R3: After the off period, `vcc_sel` switches to VCC_ON_CODE. It holds that code for RAMP_US × TICKS_PER_US cycles before card reset is asserted.
- R4: `card_rst` is high for exactly RST_US × TICKS_PER_US cycles, and only while `vcc_sel` is VCC_ON_CODE.
- R5: After `card_rst` falls, TAIL_US × TICKS_PER_US cycles pass. Then `done` is high for one cycle, `busy` falls on the same edge, and `vcc_sel` stays at VCC_ON_CODE afterwards.
- R6: An accepted disable command (`dis_req`) forces both supplies off on the next cycle with `busy` high. `done` follows (DRAIN_US + FALL_DIS_US) × TICKS_PER_US cycles after that first cycle.
- R7: A `card_gone` pulse starts the same power-down sequence as `dis_req`, both from idle and during an enable sequence.
- R8: While a sequence runs, `en_req` has no effect. While a power-down runs, `dis_req` and `card_gone` also have no effect.
- R9: A disable request or `card_gone` during any enable phase aborts it. On the next cycle the supplies are off and `card_rst` is low, and the full power-down timing runs from that edge.
- R10: When enable and disable are requested in the same idle cycle, the disable wins.
- R11: `done` is never high for two cycles in a row. It is only high on the cycle in which `busy` has just fallen.
- R12: `vpp_sel` never leaves VPP_OFF_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_req | input | 1 | Power-up command, one-cycle pulse |
| dis_req | input | 1 | Power-down command, one-cycle pulse |
| card_gone | input | 1 | Card-removal event, one-cycle pulse |
| vcc_sel | output | 2 | Card supply select code |
| vpp_sel | output | 2 | Programming supply select code |
| card_rst | output | 1 | Card reset, active high |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle pulse at the end of a sequence |

## Verification
The bench walks a full power-up cycle by cycle. It checks the exact cycle in which the supply switches on, the reset width, and the cycle of the done pulse. A counter that was off by one, or reloaded with the full count rather than count minus one, shifts these edges and fails. It re-sends enable in the middle of a sequence, where a design that restarted would report done late. It sends removal and disable in the ramp and reset phases: a design that let reset linger, or kept the old timer value, would show `card_rst` high or an early done. The bench also sends enable and disable in the same cycle, and sends enable during a power-down. Either mistake leaves the supply switched on.

// File: rtl/card_pwr_seq_pkg.sv
package card_pwr_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE      = 3'd0,
        PH_EN_DRAIN  = 3'd1,
        PH_EN_FALL   = 3'd2,
        PH_EN_RAMP   = 3'd3,
        PH_EN_PULSE  = 3'd4,
        PH_EN_TAIL   = 3'd5,
        PH_DIS_DRAIN = 3'd6,
        PH_DIS_FALL  = 3'd7
    } phase_e;

    typedef struct packed {
        phase_e     phase;
        logic [1:0] vcc;
        logic [1:0] vpp;
        logic       crst;
        logic       busy;
        logic       done;
    } seq_state_t;

    function automatic logic is_enabling(phase_e p);
        return (p == PH_EN_DRAIN) || (p == PH_EN_FALL) || (p == PH_EN_RAMP) ||
               (p == PH_EN_PULSE) || (p == PH_EN_TAIL);
    endfunction

endpackage

// File: rtl/card_pwr_seq_timer.sv
module card_pwr_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/card_pwr_seq_req.sv
module card_pwr_seq_req
    import card_pwr_seq_pkg::*;
(
    input  logic   en_req,
    input  logic   dis_req,
    input  logic   card_gone,
    input  phase_e phase,
    output logic   go_en,
    output logic   go_dis
);
    logic want_down;
    logic idle;

    always_comb begin
        want_down = dis_req | card_gone;
        idle      = (phase == PH_IDLE);
        // power-down is accepted from idle or to abort a power-up
        go_dis    = want_down && (idle || is_enabling(phase));
        // power-up only from idle and only when no power-down competes
        go_en     = en_req && idle && !want_down;
    end
endmodule

// File: rtl/card_pwr_seq_fsm.sv
module card_pwr_seq_fsm
    import card_pwr_seq_pkg::*;
#(
    parameter int            CW          = 8,
    parameter logic [1:0]    VCC_OFF     = 2'b00,
    parameter logic [1:0]    VCC_ON      = 2'b01,
    parameter logic [1:0]    VPP_OFF     = 2'b00,
    parameter logic [CW-1:0] LD_DRAIN    = '0,
    parameter logic [CW-1:0] LD_FALL_EN  = '0,
    parameter logic [CW-1:0] LD_RAMP     = '0,
    parameter logic [CW-1:0] LD_RST      = '0,
    parameter logic [CW-1:0] LD_TAIL     = '0,
    parameter logic [CW-1:0] LD_FALL_DIS = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go_en,
    input  logic          go_dis,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output phase_e        phase,
    output logic [1:0]    vcc_sel,
    output logic [1:0]    vpp_sel,
    output logic          card_rst,
    output logic          busy,
    output logic          done
);
    seq_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        load      = 1'b0;
        load_val  = '0;
        if (go_dis) begin
            st_d.phase = PH_DIS_DRAIN;
            st_d.vcc   = VCC_OFF;
            st_d.vpp   = VPP_OFF;
            st_d.crst  = 1'b0;
            st_d.busy  = 1'b1;
            load       = 1'b1;
            load_val   = LD_DRAIN;
        end else if (go_en) begin
            st_d.phase = PH_EN_DRAIN;
            st_d.vcc   = VCC_OFF;
            st_d.vpp   = VPP_OFF;
            st_d.crst  = 1'b0;
            st_d.busy  = 1'b1;
            load       = 1'b1;
            load_val   = LD_DRAIN;
        end else if (expired) begin
            unique case (st_q.phase)
                PH_EN_DRAIN: begin
                    st_d.phase = PH_EN_FALL;
                    load       = 1'b1;
                    load_val   = LD_FALL_EN;
                end
                PH_EN_FALL: begin
                    st_d.phase = PH_EN_RAMP;
                    st_d.vcc   = VCC_ON;
                    load       = 1'b1;
                    load_val   = LD_RAMP;
                end
                PH_EN_RAMP: begin
                    st_d.phase = PH_EN_PULSE;
                    st_d.crst  = 1'b1;
                    load       = 1'b1;
                    load_val   = LD_RST;
                end
                PH_EN_PULSE: begin
                    st_d.phase = PH_EN_TAIL;
                    st_d.crst  = 1'b0;
                    load       = 1'b1;
                    load_val   = LD_TAIL;
                end
                PH_DIS_DRAIN: begin
                    st_d.phase = PH_DIS_FALL;
                    load       = 1'b1;
                    load_val   = LD_FALL_DIS;
                end
                PH_EN_TAIL, PH_DIS_FALL: begin
                    st_d.phase = PH_IDLE;
                    st_d.busy  = 1'b0;
                    st_d.done  = 1'b1;
                end
                default: begin
                    st_d.phase = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.vcc   <= VCC_OFF;
            st_q.vpp   <= VPP_OFF;
            st_q.crst  <= 1'b0;
            st_q.busy  <= 1'b0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase    = st_q.phase;
    assign vcc_sel  = st_q.vcc;
    assign vpp_sel  = st_q.vpp;
    assign card_rst = st_q.crst;
    assign busy     = st_q.busy;
    assign done     = st_q.done;
endmodule

// File: rtl/card_pwr_seq.sv
module card_pwr_seq
    import card_pwr_seq_pkg::*;
#(
    parameter int unsigned TICKS_PER_US = 100,
    parameter int unsigned DRAIN_US     = 20000,
    parameter int unsigned FALL_EN_US   = 400000,
    parameter int unsigned RAMP_US      = 420000,
    parameter int unsigned RST_US       = 10,
    parameter int unsigned TAIL_US      = 20000,
    parameter int unsigned FALL_DIS_US  = 300000,
    parameter logic [1:0]  VCC_OFF_CODE = 2'b00,
    parameter logic [1:0]  VCC_ON_CODE  = 2'b01,
    parameter logic [1:0]  VPP_OFF_CODE = 2'b00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_req,
    input  logic       dis_req,
    input  logic       card_gone,
    output logic [1:0] vcc_sel,
    output logic [1:0] vpp_sel,
    output logic       card_rst,
    output logic       busy,
    output logic       done
);
    localparam int unsigned M1      = (DRAIN_US > FALL_EN_US) ? DRAIN_US : FALL_EN_US;
    localparam int unsigned M2      = (RAMP_US > RST_US) ? RAMP_US : RST_US;
    localparam int unsigned M3      = (TAIL_US > FALL_DIS_US) ? TAIL_US : FALL_DIS_US;
    localparam int unsigned M12     = (M1 > M2) ? M1 : M2;
    localparam int unsigned MAX_US  = (M12 > M3) ? M12 : M3;
    localparam int unsigned MAX_TK  = MAX_US * TICKS_PER_US;
    localparam int          CW      = (MAX_TK < 2) ? 1 : $clog2(MAX_TK);

    localparam logic [CW-1:0] LD_DRAIN    = CW'(DRAIN_US    * TICKS_PER_US - 1);
    localparam logic [CW-1:0] LD_FALL_EN  = CW'(FALL_EN_US  * TICKS_PER_US - 1);
    localparam logic [CW-1:0] LD_RAMP     = CW'(RAMP_US     * TICKS_PER_US - 1);
    localparam logic [CW-1:0] LD_RST      = CW'(RST_US      * TICKS_PER_US - 1);
    localparam logic [CW-1:0] LD_TAIL     = CW'(TAIL_US     * TICKS_PER_US - 1);
    localparam logic [CW-1:0] LD_FALL_DIS = CW'(FALL_DIS_US * TICKS_PER_US - 1);

    logic          go_en, go_dis, expired, load;
    logic [CW-1:0] load_val;
    phase_e        phase;

    card_pwr_seq_req u_req (
        .en_req    (en_req),
        .dis_req   (dis_req),
        .card_gone (card_gone),
        .phase     (phase),
        .go_en     (go_en),
        .go_dis    (go_dis)
    );

    card_pwr_seq_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    card_pwr_seq_fsm #(
        .CW          (CW),
        .VCC_OFF     (VCC_OFF_CODE),
        .VCC_ON      (VCC_ON_CODE),
        .VPP_OFF     (VPP_OFF_CODE),
        .LD_DRAIN    (LD_DRAIN),
        .LD_FALL_EN  (LD_FALL_EN),
        .LD_RAMP     (LD_RAMP),
        .LD_RST      (LD_RST),
        .LD_TAIL     (LD_TAIL),
        .LD_FALL_DIS (LD_FALL_DIS)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_en    (go_en),
        .go_dis   (go_dis),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .phase    (phase),
        .vcc_sel  (vcc_sel),
        .vpp_sel  (vpp_sel),
        .card_rst (card_rst),
        .busy     (busy),
        .done     (done)
    );
endmodule

// File: rtl/card_pwr_seq_chk.sv
module card_pwr_seq_chk #(
    parameter logic [1:0]  VCC_ON  = 2'b01,
    parameter logic [1:0]  VCC_OFF = 2'b00,
    parameter logic [1:0]  VPP_OFF = 2'b00,
    parameter int unsigned RST_TK  = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_req,
    input logic       dis_req,
    input logic       card_gone,
    input logic [1:0] vcc_sel,
    input logic [1:0] vpp_sel,
    input logic       card_rst,
    input logic       busy,
    input logic       done
);
    logic [31:0] rst_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rst_run_q <= '0;
        else if (card_rst) rst_run_q <= rst_run_q + 1;
        else               rst_run_q <= '0;
    end

    // R11
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R12
    vpp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vpp_sel == VPP_OFF);

    // R4
    rst_needs_vcc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (vcc_sel == VCC_ON));

    // R4
    rst_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (rst_run_q < RST_TK));

    // R9
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && card_rst && (dis_req || card_gone)) |=>
            (vcc_sel == VCC_OFF && !card_rst && busy));

    // R8
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en_req && !dis_req && !card_gone && card_rst) |=> !done);
endmodule

bind card_pwr_seq card_pwr_seq_chk #(
    .VCC_ON  (VCC_ON_CODE),
    .VCC_OFF (VCC_OFF_CODE),
    .VPP_OFF (VPP_OFF_CODE),
    .RST_TK  (RST_US * TICKS_PER_US)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_req    (en_req),
    .dis_req   (dis_req),
    .card_gone (card_gone),
    .vcc_sel   (vcc_sel),
    .vpp_sel   (vpp_sel),
    .card_rst  (card_rst),
    .busy      (busy),
    .done      (done)
);

// File: tb/card_pwr_seq_test.sv
`timescale 1ns/1ps
module card_pwr_seq_test;
    localparam logic [1:0] OFF = 2'b00;
    localparam logic [1:0] ON  = 2'b10;
    localparam logic [1:0] VPO = 2'b00;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_req = 1'b0, dis_req = 1'b0, card_gone = 1'b0;
    logic [1:0] vcc_sel, vpp_sel;
    logic card_rst, busy, done;
    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    // 3 + 5 + 6 + 2 + 3 cycles enable, 3 + 4 cycles disable
    card_pwr_seq #(
        .TICKS_PER_US(1), .DRAIN_US(3), .FALL_EN_US(5), .RAMP_US(6),
        .RST_US(2), .TAIL_US(3), .FALL_DIS_US(4),
        .VCC_OFF_CODE(OFF), .VCC_ON_CODE(ON), .VPP_OFF_CODE(VPO)
    ) uut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .card_gone(card_gone), .vcc_sel(vcc_sel), .vpp_sel(vpp_sel),
        .card_rst(card_rst), .busy(busy), .done(done)
    );

    // per observed cycle n=1..21 after an accepted enable:
    // {inject en_req after this cycle, vcc on, card_rst, busy, done}
    localparam logic [4:0] EN_VEC [0:20] = '{
        5'b00010, 5'b00010, 5'b00010, 5'b00010, 5'b10010,
        5'b00010, 5'b00010, 5'b00010, 5'b01010, 5'b01010,
        5'b01010, 5'b01010, 5'b01010, 5'b01010, 5'b01110,
        5'b11110, 5'b01010, 5'b01010, 5'b01010, 5'b01001,
        5'b01000
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(logic e, logic d, logic g);
        en_req = e; dis_req = d; card_gone = g;
        step();
        en_req = 1'b0; dis_req = 1'b0; card_gone = 1'b0;
    endtask

    // after a power-down edge: m=1 observed now; done expected at m=8
    task automatic expect_down(string req);
        chk({req, " vcc off"}, vcc_sel, OFF);
        chk({req, " rst low"}, card_rst, 0);
        chk({req, " busy"}, busy, 1);
        repeat (6) step();
        chk({req, " busy before done"}, busy, 1);
        chk({req, " no early done"}, done, 0);
        step();
        chk({req, " done"}, done, 1);
        chk({req, " busy fell"}, busy, 0);
        step();
        chk({req, " done single"}, done, 0);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 vcc", vcc_sel, OFF);
        chk("R1 vpp", vpp_sel, VPO);
        chk("R1 rst", card_rst, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        rst_n = 1'b1;
        step();

        // R2 R3 R4 R5 R8 R12: table walk of a full power-up
        pulse(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 21; i++) begin
            chk($sformatf("R2/R3 vcc n=%0d", i+1), vcc_sel, EN_VEC[i][3] ? ON : OFF);
            chk($sformatf("R4 rst n=%0d", i+1), card_rst, EN_VEC[i][2]);
            chk($sformatf("R5 busy n=%0d", i+1), busy, EN_VEC[i][1]);
            chk($sformatf("R5 done n=%0d", i+1), done, EN_VEC[i][0]);
            chk($sformatf("R12 vpp n=%0d", i+1), vpp_sel, VPO);
            en_req = EN_VEC[i][4];   // R8: re-sent enable must not restart
            step();
            en_req = 1'b0;
        end

        // R6 R8: power-down from powered idle, enable sent at m=3 ignored
        pulse(1'b0, 1'b1, 1'b0);
        chk("R6 vcc off", vcc_sel, OFF);
        chk("R6 busy", busy, 1);
        step(); step();
        pulse(1'b1, 1'b0, 1'b0);
        repeat (3) step();
        chk("R6 no early done", done, 0);
        step();
        chk("R6 done", done, 1);
        step();
        chk("R8 enable ignored vcc", vcc_sel, OFF);
        chk("R8 enable ignored busy", busy, 0);

        // R9: disable during ramp (n=10)
        pulse(1'b1, 1'b0, 1'b0);
        repeat (9) step();
        chk("R9 vcc on before abort", vcc_sel, ON);
        pulse(1'b0, 1'b1, 1'b0);
        expect_down("R9 ramp abort");

        // R7 R9: removal during reset pulse (n=15)
        pulse(1'b1, 1'b0, 1'b0);
        repeat (14) step();
        chk("R7 rst high before removal", card_rst, 1);
        pulse(1'b0, 1'b0, 1'b1);
        expect_down("R7 removal in pulse");

        // R7: removal from powered idle
        pulse(1'b1, 1'b0, 1'b0);
        repeat (20) step();
        chk("R7 powered", vcc_sel, ON);
        pulse(1'b0, 1'b0, 1'b1);
        expect_down("R7 removal idle");

        // R10: both at once
        pulse(1'b1, 1'b1, 1'b0);
        expect_down("R10 disable wins");
        repeat (10) step();
        chk("R10 vcc stays off", vcc_sel, OFF);

        // R1: reset mid-sequence
        pulse(1'b1, 1'b0, 1'b0);
        repeat (14) step();
        rst_n = 1'b0;
        step();
        chk("R1 mid vcc", vcc_sel, OFF);
        chk("R1 mid rst", card_rst, 0);
        chk("R1 mid busy", busy, 0);
        rst_n = 1'b1;
        step();

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule